// File: doc/BRIEF.md
# Single-Cycle 4x4 Intra Prediction Core

This block turns the reconstructed samples around a 4x4 block into all sixteen prediction samples of that block in one pass. Each cycle it can take a new request made of four left samples, eight samples above (four directly above and four above-right), the corner sample, three availability flags and a mode code. One cycle later it returns the sixteen predicted samples together with the mode and size tags of the request. Requests can arrive back to back, one per clock.

All directional modes share a single network of pair sums. From those sums the core forms a pool of rounded two-tap averages and three-tap smoothed values, and a per-position selector picks the right pool entry for the requested mode. The same pair sums are regrouped into one four-sample sum for the left edge and one for the top edge, which gives the DC value of a 4x4 block in the same cycle. For 8x8 and 16x16 DC, the driver feeds the edge samples in 4x4 slices over two or four beats. A dedicated accumulator adds the beats together, and the finished value is kept in a holding register until the next large DC completes. Ordinary 4x4 requests, including 4x4 DC, may be interleaved between the beats.

Top module: `intra4_core`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid is 0 and out_pred and out_dc_held are all zero.
- R2: A request accepted with in_valid high produces out_valid high on the next cycle, with out_mode and out_size equal to the request's in_mode and in_size. The only exception is a non-final large DC beat (see R8). A cycle with in_valid low produces out_valid low on the next cycle. Sample (x,y) of the block is carried in out_pred[(4*y+x)*8 +: 8].
- R3: Mode 0 (vertical) copies upper sample x into every row: pred(x,y)=nb_up[x]. Mode 1 (horizontal) copies left sample y across its row: pred(x,y)=nb_left[y].
- R4: Mode 3 (down-left diagonal) and mode 4 (down-right diagonal) give every position the three-tap value (a+2b+c+2)>>2 along its diagonal. Position (3,3) of mode 3 uses (U6+3*U7+2)>>2, and mode 4 uses the corner sample where its diagonal crosses it.
- R5: Mode 5 (vertical-right), mode 6 (horizontal-down), mode 7 (vertical-left) and mode 8 (horizontal-up) mix two-tap averages (a+b+1)>>1 with three-tap values, following the standard position rules. In mode 8, position (1,2) uses (L2+3*L3+2)>>2 and every position with x+2y>5 uses L3.
- R6: With ur_avail low, the four above-right inputs are ignored and the upper sample at x=3 stands in for each of them.
- R7: A 4x4 DC request (mode 2, size code 0) fills all sixteen positions with one value: (sumL+sumU+4)>>3 when both sides are available, (sum+2)>>2 when only one side is, and 128 when neither is.
- R8: Large DC uses size code 1 (8x8, two beats) or size code 2 (16x16, four beats), with in_dc_start marking the first beat. Only the final beat yields out_valid. The result is (S+N/2)/N, where S is the sum of the samples on the available sides and N is their count, or 128 when no side is available.
- R9: out_dc_held takes the large DC result on the cycle that result is output. It stays unchanged through any other traffic, including 4x4 requests interleaved between beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| in_mode | input | 4 | Prediction mode code 0..8 |
| in_size | input | 2 | Block size code: 0 4x4, 1 8x8, 2 16x16 |
| in_dc_start | input | 1 | First beat of a large DC accumulation |
| left_avail | input | 1 | Left neighbours usable for DC |
| up_avail | input | 1 | Upper neighbours usable for DC |
| ur_avail | input | 1 | Above-right neighbours present |
| nb_left | input | 32 | Left samples, row k at [8k +: 8] |
| nb_up | input | 64 | Upper samples, column k at [8k +: 8], k=4..7 above-right |
| nb_corner | input | 8 | Sample above-left of the block |
| out_valid | output | 1 | Prediction block present |
| out_mode | output | 4 | Mode tag of the returned block |
| out_size | output | 2 | Size tag of the returned block |
| out_pred | output | 128 | Sixteen predicted samples |
| out_dc_held | output | 8 | Last finished 8x8/16x16 DC value |

## Verification
The embedded checks assume the driver sends only mode codes 0 to 8 and never uses size code 3. They also assume that a large DC continuation beat only follows a start beat of the same block that has not yet finished, and that the availability flags do not change across the beats of one large DC. The stimulus respects all of this. It draws directional and 4x4 DC requests freely, including random ones, but issues each large DC as an ordered run of beats with fixed flags, interleaving only 4x4 requests and idle cycles between them.

// File: rtl/intra4_pkg.sv
`timescale 1ns/1ps
package intra4_pkg;

    localparam int SAMPLE_W = 8;
    localparam int ROWS     = 4;
    localparam int PIX_N    = ROWS * ROWS;
    // neighbour chain: L3 L2 L1 L0 corner U0 .. U7
    localparam int CHAIN_N  = 2 * ROWS + ROWS + 1;
    localparam int TAP_N    = CHAIN_N - 1;
    // pair sums regrouped into edge sums for DC
    localparam int LEFT_PA  = 0;
    localparam int LEFT_PB  = 2;
    localparam int UP_PA    = ROWS + 1;
    localparam int UP_PB    = ROWS + 3;

    typedef enum logic [3:0] {
        P_VERT = 4'd0,
        P_HORZ = 4'd1,
        P_DC   = 4'd2,
        P_DDL  = 4'd3,
        P_DDR  = 4'd4,
        P_VR   = 4'd5,
        P_HD   = 4'd6,
        P_VL   = 4'd7,
        P_HU   = 4'd8
    } pmode_e;

    typedef enum logic [2:0] {
        SRC_RAW,
        SRC_AVG2,
        SRC_TAP3,
        SRC_TAP3_END,
        SRC_DC,
        SRC_NONE
    } src_kind_e;

    typedef struct packed {
        src_kind_e  kind;
        logic [3:0] idx;
    } src_sel_t;

    function automatic src_sel_t mk(src_kind_e k, int i);
        src_sel_t r;
        r.kind = k;
        r.idx  = 4'(i);
        return r;
    endfunction

    // Chooses the pool entry for position (x,y) under a given mode.
    function automatic src_sel_t pick_src(logic [3:0] mode, int x, int y);
        int z;
        int k;
        src_sel_t r;
        r = mk(SRC_NONE, 0);
        case (mode)
            P_VERT: r = mk(SRC_RAW, 5 + x);
            P_HORZ: r = mk(SRC_RAW, 3 - y);
            P_DC:   r = mk(SRC_DC, 0);
            P_DDL:  r = mk(SRC_TAP3, 5 + x + y);
            P_DDR:  r = mk(SRC_TAP3, 3 + x - y);
            P_VR: begin
                z = 2 * x - y;
                if (z >= 0 && (z % 2) == 0) r = mk(SRC_AVG2, 4 + x - (y >> 1));
                else if (z >= -1)           r = mk(SRC_TAP3, 3 + x - (y >> 1));
                else                        r = mk(SRC_TAP3, 4 - y);
            end
            P_HD: begin
                z = 2 * y - x;
                if (z >= 0 && (z % 2) == 0) r = mk(SRC_AVG2, 3 - y + (x >> 1));
                else if (z >= -1)           r = mk(SRC_TAP3, 3 - y + (x >> 1));
                else                        r = mk(SRC_TAP3, 2 + x);
            end
            P_VL: begin
                if ((y % 2) == 0) r = mk(SRC_AVG2, 5 + x + (y >> 1));
                else              r = mk(SRC_TAP3, 5 + x + (y >> 1));
            end
            P_HU: begin
                z = x + 2 * y;
                k = y + (x >> 1);
                if (z > 5)             r = mk(SRC_RAW, 0);
                else if (z == 5)       r = mk(SRC_TAP3_END, 0);
                else if ((z % 2) == 0) r = mk(SRC_AVG2, 2 - k);
                else                   r = mk(SRC_TAP3, 1 - k);
            end
            default: r = mk(SRC_NONE, 0);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/intra4_pool.sv
`timescale 1ns/1ps
module intra4_pool #(
    parameter int SW = intra4_pkg::SAMPLE_W,
    parameter int N  = intra4_pkg::CHAIN_N
) (
    input  logic [SW-1:0] chain    [N],
    output logic [SW-1:0] avg2     [N-1],
    output logic [SW-1:0] tap3     [N-1],
    output logic [SW-1:0] tap3_end,
    output logic [SW+1:0] sum_left,
    output logic [SW+1:0] sum_up
);
    import intra4_pkg::*;

    localparam int PW = SW + 1;
    localparam int QW = SW + 2;

    // first level: sums of neighbouring pairs; the last entry doubles the far end
    logic [PW-1:0] pair [N];

    for (genvar i = 0; i < N; i++) begin : g_pair
        if (i < N - 1) begin : g_mid
            assign pair[i] = PW'(chain[i]) + PW'(chain[i + 1]);
        end else begin : g_end
            assign pair[i] = {chain[i], 1'b0};
        end
    end

    // second level: rounded averages and three-tap smoothing from the same sums
    for (genvar i = 0; i < N - 1; i++) begin : g_lvl
        assign avg2[i] = SW'((pair[i] + PW'(1)) >> 1);
        assign tap3[i] = SW'((QW'(pair[i]) + QW'(pair[i + 1]) + QW'(2)) >> 2);
    end

    assign tap3_end = SW'((QW'({chain[0], 1'b0}) + QW'(pair[0]) + QW'(2)) >> 2);

    // DC configuration: pair sums regrouped into edge sums
    assign sum_left = QW'(pair[LEFT_PA]) + QW'(pair[LEFT_PB]);
    assign sum_up   = QW'(pair[UP_PA])   + QW'(pair[UP_PB]);

endmodule

// File: rtl/intra4_dc.sv
`timescale 1ns/1ps
module intra4_dc #(
    parameter int SW    = intra4_pkg::SAMPLE_W,
    parameter int ACC_W = SW + 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fire,
    input  logic [1:0]    size,
    input  logic          start,
    input  logic          left_av,
    input  logic          up_av,
    input  logic [SW+1:0] sum_left,
    input  logic [SW+1:0] sum_up,
    output logic          done,
    output logic [SW-1:0] value,
    output logic [SW-1:0] held
);
    localparam logic [SW-1:0] MID = SW'(1) << (SW - 1);

    logic [ACC_W-1:0] acc, base, total;
    logic [2:0]       cnt, cnt_n;
    logic [4:0]       sh;
    logic             big, fresh;

    always_comb begin
        big   = size != 2'd0;
        fresh = !big || start;
        base  = fresh ? '0 : acc;
        total = base + (left_av ? ACC_W'(sum_left) : '0)
                     + (up_av   ? ACC_W'(sum_up)   : '0);
        cnt_n = fresh ? 3'd1 : cnt + 3'd1;
        done  = cnt_n == (3'd1 << size);
        sh    = 5'd2 + {3'b000, size} + {4'b0000, left_av && up_av};
        if (!left_av && !up_av)
            value = MID;
        else
            value = SW'((total + (ACC_W'(1) << (sh - 5'd1))) >> sh);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            cnt  <= '0;
            held <= '0;
        end else if (fire && big) begin
            acc <= total;
            cnt <= done ? 3'd0 : cnt_n;
            if (done) held <= value;
        end
    end

    // R8
    cont_in_block_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && big && !start) |-> (cnt != 3'd0));

    // R8
    size_code_chk: assert property (@(posedge clk) disable iff (rst)
        fire |-> (size != 2'd3));

endmodule

// File: rtl/intra4_core.sv
`timescale 1ns/1ps
module intra4_core #(
    parameter int SW = intra4_pkg::SAMPLE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [3:0]           in_mode,
    input  logic [1:0]           in_size,
    input  logic                 in_dc_start,
    input  logic                 left_avail,
    input  logic                 up_avail,
    input  logic                 ur_avail,
    input  logic [4*SW-1:0]      nb_left,
    input  logic [8*SW-1:0]      nb_up,
    input  logic [SW-1:0]        nb_corner,
    output logic                 out_valid,
    output logic [3:0]           out_mode,
    output logic [1:0]           out_size,
    output logic [16*SW-1:0]     out_pred,
    output logic [SW-1:0]        out_dc_held
);
    import intra4_pkg::*;

    localparam int UP_N = 2 * ROWS;

    logic [SW-1:0] chain [CHAIN_N];
    logic [SW-1:0] avg2  [TAP_N];
    logic [SW-1:0] tap3  [TAP_N];
    logic [SW-1:0] tap3_end;
    logic [SW+1:0] sum_left, sum_up;
    logic [SW-1:0] dc_value;
    logic          dc_fire, dc_done;
    logic [PIX_N*SW-1:0] pred_d;

    // neighbour chain, with above-right replaced by U3 when absent
    for (genvar k = 0; k < ROWS; k++) begin : g_left
        assign chain[ROWS - 1 - k] = nb_left[k*SW +: SW];
    end
    assign chain[ROWS] = nb_corner;
    for (genvar k = 0; k < UP_N; k++) begin : g_up
        if (k < ROWS) begin : g_near
            assign chain[ROWS + 1 + k] = nb_up[k*SW +: SW];
        end else begin : g_far
            assign chain[ROWS + 1 + k] = ur_avail ? nb_up[k*SW +: SW]
                                                  : nb_up[(ROWS-1)*SW +: SW];
        end
    end

    intra4_pool #(.SW(SW), .N(CHAIN_N)) u_pool (
        .chain    (chain),
        .avg2     (avg2),
        .tap3     (tap3),
        .tap3_end (tap3_end),
        .sum_left (sum_left),
        .sum_up   (sum_up)
    );

    assign dc_fire = in_valid && (in_mode == P_DC);

    intra4_dc #(.SW(SW)) u_dc (
        .clk      (clk),
        .rst      (rst),
        .fire     (dc_fire),
        .size     (in_size),
        .start    (in_dc_start),
        .left_av  (left_avail),
        .up_av    (up_avail),
        .sum_left (sum_left),
        .sum_up   (sum_up),
        .done     (dc_done),
        .value    (dc_value),
        .held     (out_dc_held)
    );

    // output selector: one multiplexer per position over the shared pool
    for (genvar p = 0; p < PIX_N; p++) begin : g_pix
        localparam int PX = p % ROWS;
        localparam int PY = p / ROWS;
        src_sel_t      s;
        logic [SW-1:0] pix;
        always_comb begin
            s = pick_src(in_mode, PX, PY);
            case (s.kind)
                SRC_RAW:      pix = chain[s.idx];
                SRC_AVG2:     pix = avg2[s.idx];
                SRC_TAP3:     pix = tap3[s.idx];
                SRC_TAP3_END: pix = tap3_end;
                SRC_DC:       pix = dc_value;
                default:      pix = '0;
            endcase
        end
        assign pred_d[p*SW +: SW] = pix;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_mode  <= '0;
            out_size  <= '0;
            out_pred  <= '0;
        end else begin
            out_valid <= in_valid && (!dc_fire || dc_done);
            if (in_valid) begin
                out_mode <= in_mode;
                out_size <= in_size;
                out_pred <= pred_d;
            end
        end
    end

    // R2
    issue_to_out_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !(in_mode == P_DC && in_size != 2'd0)) |=> out_valid);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R2
    mode_tag_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (out_mode == $past(in_mode)));

    // R3
    vert_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == P_VERT) |=> (out_pred[SW-1:0] == $past(nb_up[SW-1:0])));

    // R9
    held_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !(in_valid && in_mode == P_DC && in_size != 2'd0) |=> $stable(out_dc_held));

    // R7
    dc_flat_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_mode == P_DC) |-> (out_pred[SW-1:0] == out_pred[PIX_N*SW-1 -: SW]));

endmodule

// File: tb/intra4_core_test.sv
`timescale 1ns/1ps
module intra4_core_test;

    localparam int SW = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [3:0]      in_mode = '0;
    logic [1:0]      in_size = '0;
    logic            in_dc_start = 1'b0;
    logic            left_avail = 1'b0, up_avail = 1'b0, ur_avail = 1'b0;
    logic [4*SW-1:0] nb_left = '0;
    logic [8*SW-1:0] nb_up = '0;
    logic [SW-1:0]   nb_corner = '0;
    logic            out_valid;
    logic [3:0]      out_mode;
    logic [1:0]      out_size;
    logic [16*SW-1:0] out_pred;
    logic [SW-1:0]   out_dc_held;

    intra4_core #(.SW(SW)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_size(in_size), .in_dc_start(in_dc_start), .left_avail(left_avail),
        .up_avail(up_avail), .ur_avail(ur_avail), .nb_left(nb_left),
        .nb_up(nb_up), .nb_corner(nb_corner), .out_valid(out_valid),
        .out_mode(out_mode), .out_size(out_size), .out_pred(out_pred),
        .out_dc_held(out_dc_held)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    int L[4];
    int U[8];
    int Q;
    bit cur_ur;
    int ref_sum = 0, ref_cnt = 0, ref_held = 0;

    task automatic chk(bit ok, string tag, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    function automatic int p(int x, int y);
        if (y < 0) begin
            if (x < 0) return Q;
            if (x > 3 && !cur_ur) return U[3];
            return U[x];
        end
        return L[y];
    endfunction

    function automatic int t3(int a, int b, int c);
        return (a + 2 * b + c + 2) >> 2;
    endfunction

    function automatic int a2(int a, int b);
        return (a + b + 1) >> 1;
    endfunction

    // reference prediction written from the mode definitions
    function automatic int rp(int m, int x, int y);
        int z, k;
        case (m)
            0: return p(x, -1);
            1: return p(-1, y);
            3: begin
                if (x == 3 && y == 3) return (p(6, -1) + 3 * p(7, -1) + 2) >> 2;
                return t3(p(x+y, -1), p(x+y+1, -1), p(x+y+2, -1));
            end
            4: begin
                if (x > y) return t3(p(x-y-2, -1), p(x-y-1, -1), p(x-y, -1));
                if (x < y) return t3(p(-1, y-x-2), p(-1, y-x-1), p(-1, y-x));
                return t3(p(0, -1), p(-1, -1), p(-1, 0));
            end
            5: begin
                z = 2 * x - y;
                k = x - (y >> 1);
                if (z >= 0 && z % 2 == 0) return a2(p(k-1, -1), p(k, -1));
                if (z > 0) return t3(p(k-2, -1), p(k-1, -1), p(k, -1));
                if (z == -1) return t3(p(-1, 0), p(-1, -1), p(0, -1));
                return t3(p(-1, y-1), p(-1, y-2), p(-1, y-3));
            end
            6: begin
                z = 2 * y - x;
                k = y - (x >> 1);
                if (z >= 0 && z % 2 == 0) return a2(p(-1, k-1), p(-1, k));
                if (z > 0) return t3(p(-1, k-2), p(-1, k-1), p(-1, k));
                if (z == -1) return t3(p(-1, 0), p(-1, -1), p(0, -1));
                return t3(p(x-1, -1), p(x-2, -1), p(x-3, -1));
            end
            7: begin
                k = x + (y >> 1);
                if (y % 2 == 0) return a2(p(k, -1), p(k+1, -1));
                return t3(p(k, -1), p(k+1, -1), p(k+2, -1));
            end
            8: begin
                z = x + 2 * y;
                k = y + (x >> 1);
                if (z > 5) return p(-1, 3);
                if (z == 5) return (p(-1, 2) + 3 * p(-1, 3) + 2) >> 2;
                if (z % 2 == 0) return a2(p(-1, k), p(-1, k+1));
                return t3(p(-1, k), p(-1, k+1), p(-1, k+2));
            end
            default: return 0;
        endcase
    endfunction

    task automatic setnb(int kind);
        for (int k = 0; k < 8; k++) begin
            case (kind)
                1: U[k] = 255;
                2: U[k] = 0;
                3: U[k] = 220 - 25 * k;
                default: U[k] = int'($urandom_range(0, 255));
            endcase
        end
        for (int k = 0; k < 4; k++) begin
            case (kind)
                1: L[k] = 255;
                2: L[k] = 0;
                3: L[k] = 15 + 45 * k;
                default: L[k] = int'($urandom_range(0, 255));
            endcase
        end
        case (kind)
            1: Q = 255;
            2: Q = 0;
            3: Q = 111;
            default: Q = int'($urandom_range(0, 255));
        endcase
    endtask

    // one cycle: drive at a falling edge, check at the next falling edge
    task automatic blk(bit v, int m, int sz, bit st, bit la, bit ua, bit ura);
        bit    ev;
        int    ex[16];
        int    sl, su, val, n, bad;
        string vtag, ptag;
        in_valid    = v;
        in_mode     = 4'(m);
        in_size     = 2'(sz);
        in_dc_start = st;
        left_avail  = la;
        up_avail    = ua;
        ur_avail    = ura;
        for (int k = 0; k < 4; k++) nb_left[k*SW +: SW] = 8'(L[k]);
        for (int k = 0; k < 8; k++) nb_up[k*SW +: SW] = 8'(U[k]);
        nb_corner = 8'(Q);
        cur_ur = ura;
        vtag = "R2";
        ptag = "R2";
        ev = 0;
        if (v) begin
            sl = L[0] + L[1] + L[2] + L[3];
            su = U[0] + U[1] + U[2] + U[3];
            if (m == 2 && sz == 0) begin
                if (la && ua) val = (sl + su + 4) >> 3;
                else if (la)  val = (sl + 2) >> 2;
                else if (ua)  val = (su + 2) >> 2;
                else          val = 128;
                for (int i = 0; i < 16; i++) ex[i] = val;
                ev = 1;
                ptag = "R7";
            end else if (m == 2) begin
                if (st) begin ref_sum = 0; ref_cnt = 0; end
                ref_sum += (la ? sl : 0) + (ua ? su : 0);
                ref_cnt++;
                vtag = "R8";
                ptag = "R8";
                if (ref_cnt == (1 << sz)) begin
                    n = 4 * (1 << sz) * ((la ? 1 : 0) + (ua ? 1 : 0));
                    val = (n == 0) ? 128 : (ref_sum + n / 2) / n;
                    for (int i = 0; i < 16; i++) ex[i] = val;
                    ref_held = val;
                    ref_cnt = 0;
                    ev = 1;
                end
            end else begin
                for (int y = 0; y < 4; y++)
                    for (int x = 0; x < 4; x++) ex[4*y + x] = rp(m, x, y);
                ev = 1;
                if (m <= 1) ptag = "R3";
                else if (m <= 4) ptag = "R4";
                else ptag = "R5";
                if (!ura && (m == 3 || m == 7)) ptag = "R6";
            end
        end
        @(negedge clk);
        chk(out_valid == ev, vtag, "out_valid", int'(out_valid), int'(ev));
        chk(int'(out_dc_held) == ref_held, "R9", "out_dc_held", int'(out_dc_held), ref_held);
        if (ev) begin
            chk(int'(out_mode) == m, "R2", "out_mode", int'(out_mode), m);
            chk(int'(out_size) == sz, "R2", "out_size", int'(out_size), sz);
            bad = -1;
            for (int i = 15; i >= 0; i--)
                if (int'(out_pred[i*SW +: SW]) != ex[i]) bad = i;
            if (bad < 0) chk(1, ptag, "pred", 0, 0);
            else chk(0, ptag, $sformatf("mode %0d pixel %0d", m, bad),
                     int'(out_pred[bad*SW +: SW]), ex[bad]);
        end
    endtask

    task automatic interleave();
        setnb(0);
        blk(1, 3 + int'($urandom_range(0, 5)), 0, 0, 1, 1, 1'($urandom_range(0, 1)));
        setnb(0);
        blk(1, 2, 0, 1, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(0, "WATCHDOG", "run did not end", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        setnb(2);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        chk(out_dc_held == '0, "R1", "out_dc_held in reset", int'(out_dc_held), 0);
        chk(out_pred == '0, "R1", "out_pred in reset", int'(out_pred[7:0]), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);

        // R3 R4 R5 R6: directional modes over several neighbour patterns
        for (int kind = 0; kind < 4; kind++) begin
            setnb(kind);
            for (int m = 0; m < 9; m++) begin
                if (m == 2) continue;
                blk(1, m, 0, 0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1);
                blk(1, m, 0, 0, 1, 1, 0);
            end
        end
        for (int r = 0; r < 20; r++) begin
            setnb(0);
            blk(1, 3, 0, 0, 1, 1, 0);
            blk(1, 7, 0, 0, 1, 1, 0);
        end

        // R7: 4x4 DC under every availability combination
        for (int kind = 0; kind < 4; kind++) begin
            setnb(kind);
            for (int c = 0; c < 4; c++) blk(1, 2, 0, 1, 1'(c & 1), 1'(c >> 1), 1);
        end

        // R2: idle cycles carrying garbage leave the outputs quiet
        for (int r = 0; r < 5; r++) begin
            setnb(0);
            blk(0, 2, 1, 0, 1, 1, 1);
        end

        // R8 R9: 8x8 DC with interleaved 4x4 requests
        for (int c = 0; c < 4; c++) begin
            setnb(0);
            blk(1, 2, 1, 1, 1'(c & 1), 1'(c >> 1), 1);
            interleave();
            setnb(0);
            blk(1, 2, 1, 0, 1'(c & 1), 1'(c >> 1), 1);
            blk(0, 0, 0, 0, 0, 0, 0);
        end

        // R8 R9: 16x16 DC, back to back and interleaved
        for (int c = 0; c < 4; c++) begin
            for (int b = 0; b < 4; b++) begin
                setnb(c == 3 ? 1 : 0);
                blk(1, 2, 2, b == 0, 1'(c != 1), 1'(c != 2), 1);
                if (b == 1) interleave();
                if (b == 2) blk(0, 0, 0, 0, 0, 0, 0);
            end
        end
        for (int b = 0; b < 4; b++) begin
            setnb(2);
            blk(1, 2, 2, b == 0, 0, 0, 1);
        end
        setnb(3);
        blk(1, 2, 1, 1, 1, 1, 1);
        blk(1, 2, 1, 0, 1, 1, 1);

        // R2 R3 R4 R5 R6 R7: mixed random stream
        for (int r = 0; r < 400; r++) begin
            setnb(0);
            blk(1'($urandom_range(0, 7) != 0), int'($urandom_range(0, 8)), 0, 1,
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule